// File: doc/BRIEF.md
# Remote Terminal Status Flag Manager

This block keeps the status bits that a serial-bus remote terminal reports back to the bus controller. These are the terminal flag, the subsystem flag, message error, busy, service request and dynamic-bus-control acceptance. It also keeps three sticky self-test fault bits. It does not decode commands itself. An upstream decoder hands it a one-cycle command strobe with the subaddress, the transmit/receive bit and the five-bit mode code or word count field. Fault detectors and the subsystem drive event and level inputs.

Each accepted command starts a short response window. The subsystem's busy and service-request lines are sampled at a fixed point in that window. A message-error request edge is accepted only during an early part of the window. At the end of the window the block presents the status bits to transmit, together with a one-cycle valid pulse.

Two mode commands replay the previously transmitted status bits instead of a fresh set: transmit-status and transmit-last-command. Four active-low option inputs select when the terminal and subsystem flags are cleared relative to those replaying commands.

Top module: `rt_status_mgr`

## Requirements
- R1: While `rst_n` is low, and after it rises, `resp_vld`, `resp_word`, `bit_word` and `dbc_req` are zero. The terminal-flag inhibit is also cleared by this power-up reset.
- R2: A strobe on `cmd_valid` at clock edge E0 gives `resp_vld` high for exactly one cycle after edge E4. `resp_word` holds, from bit 5 down to bit 0: message error, service request, busy, subsystem flag, bus-control acceptance, terminal flag. Busy and service request are the inverted `busy_n`/`srq_n` seen at edge E2; a level first seen at E3 is not reported.
- R3: Any one of `tx_timeout`, `loop_fail`, `selftest_fail` or `addr_par_err` sets the terminal flag. `bit_word` bit 0 records a transmitter timeout, bit 1 a handshake failure and bit 2 a loop test failure. These bits can only rise after their own event.
- R4: `hs_fail` sets the subsystem flag and `bit_word` bit 1. While `ss_err_n` is low, the subsystem flag is reported in every freshly built response.
- R5: The reset-terminal mode command (code 01000) clears both flags, all `bit_word` bits and the terminal-flag inhibit before its own response is built.
- R6: Mode code 00110 stops the terminal flag from being reported as 1. Code 00111 lifts that, and so does R5 or R1.
- R7: With `opt_en_n` high, the flags and `bit_word` are sticky. They clear only per R1 or R5.
- R8: With `opt_en_n` low and no other option low, any accepted command other than transmit-status or transmit-last-command clears the flags and `bit_word` on receipt.
- R9: With `opt_en_n` and `opt_upd_n` low, a fault also marks the replay copy at once. A following transmit-status or transmit-last-command therefore shows the flag, and keeps showing it while repeated. The next other command clears it.
- R10: With `opt_en_n` and `opt_next_n` low, the first non-replay command after a fault is not clearing and its response shows the flag. The next non-replay command clears it.
- R11: With `opt_en_n` and `opt_bit_n` low, transmit-BIT-word (code 10011) keeps the flags and `bit_word` if it directly follows a fault, either alone or after replay commands. Otherwise it clears as in R8.
- R12: A mode command is subaddress 0 or 31 with the transmit bit set. Transmit-status (00010) and transmit-last-command (10010) return the last freshly built `resp_word` unchanged. Every other command's response becomes the new replay copy.
- R13: A rising edge on `meq` seen at edges E1 to E3 sets message error in the response; an edge at E4 does not.
- R14: With `dbc_acc_n` low, the bus-control mode command (code 00000) sets `resp_word` bit 1 and pulses `dbc_req` together with `resp_vld`. With `dbc_acc_n` high, neither happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| cmd_valid | input | 1 | One-cycle strobe: a valid command for this terminal |
| cmd_sa | input | 5 | Subaddress of the command |
| cmd_tx | input | 1 | Transmit/receive bit of the command (1 = transmit) |
| cmd_code | input | 5 | Mode code or word count field |
| busy_n | input | 1 | Subsystem busy, active low |
| srq_n | input | 1 | Subsystem service request, active low |
| meq | input | 1 | Message error request, rising edge counts |
| ss_err_n | input | 1 | Subsystem error level, active low |
| hs_fail | input | 1 | Subsystem handshake failure event |
| tx_timeout | input | 1 | Transmitter timeout event |
| loop_fail | input | 1 | Loop test failure event |
| selftest_fail | input | 1 | Self-test failure event |
| addr_par_err | input | 1 | Terminal address parity error event |
| dbc_acc_n | input | 1 | Bus-control acceptance, active low |
| opt_en_n | input | 1 | Enables the selectable flag-clear policies |
| opt_upd_n | input | 1 | Policy: mark replay copy at fault |
| opt_next_n | input | 1 | Policy: report in next status |
| opt_bit_n | input | 1 | Policy: preserve through transmit-BIT-word |
| resp_word | output | 6 | Status bits to transmit |
| resp_vld | output | 1 | One-cycle pulse: `resp_word` updated |
| bit_word | output | 3 | Sticky self-test fault bits |
| dbc_req | output | 1 | Bus-control takeover request pulse |

## Verification
A wrong flag, inhibit or fault-tracking state does not show at once. It shows in the `resp_word` of the next command whose response is built fresh, four edges after its strobe. A corrupted replay copy shows only when a transmit-status or transmit-last-command arrives, so the sequences alternate replaying and non-replaying commands after every fault. The fault bits surface on `bit_word` on the cycle after their event or clear. Each flag-clear policy is therefore walked through fault, replay and ordinary commands in the orders where the policies disagree.

// File: rtl/rt_stat_pkg.sv
// Shared types and codes for the status flag manager.
// Assumes five-bit subaddress and mode code fields.
package rt_stat_pkg;
    localparam int SA_W  = 5;
    localparam int MC_W  = 5;
    localparam int BIT_N = 3;

    // Positions inside the sticky fault word.
    localparam int BIT_TXTO = 0;
    localparam int BIT_HS   = 1;
    localparam int BIT_LOOP = 2;

    // Mode codes recognised by the classifier.
    localparam logic [MC_W-1:0] MC_DBC     = 5'b00000;
    localparam logic [MC_W-1:0] MC_TX_STAT = 5'b00010;
    localparam logic [MC_W-1:0] MC_INH_TF  = 5'b00110;
    localparam logic [MC_W-1:0] MC_OVR_TF  = 5'b00111;
    localparam logic [MC_W-1:0] MC_RST_RT  = 5'b01000;
    localparam logic [MC_W-1:0] MC_TX_LAST = 5'b10010;
    localparam logic [MC_W-1:0] MC_TX_BIT  = 5'b10011;

    // Status bits in transmit order, most significant first.
    typedef struct packed {
        logic me;
        logic srq;
        logic busy;
        logic ssf;
        logic dbca;
        logic tf;
    } stat_t;

    // One-hot-or-zero class of a decoded command.
    typedef struct packed {
        logic rd_last;
        logic tx_bit;
        logic inh_tf;
        logic ovr_tf;
        logic rst_rt;
        logic dbc;
    } cmd_cls_t;
endpackage

// File: rtl/rt_cmd_class.sv
// Combinational classifier: turns subaddress, T/R bit and code field into
// the command classes that matter for status handling. Assumes a mode
// command is subaddress all-zeros or all-ones; only transmit-direction
// mode codes are recognised.
module rt_cmd_class
    import rt_stat_pkg::*;
(
    input  logic [SA_W-1:0] sa,
    input  logic            tx,
    input  logic [MC_W-1:0] code,
    output cmd_cls_t        cls
);
    logic mode_tx;

    // Mode command in the transmit direction.
    assign mode_tx = ((sa == '0) || (sa == '1)) && tx;

    // Decode the recognised mode codes.
    always_comb begin
        cls = '0;
        if (mode_tx) begin
            cls.rd_last = (code == MC_TX_STAT) || (code == MC_TX_LAST);
            cls.tx_bit  = (code == MC_TX_BIT);
            cls.inh_tf  = (code == MC_INH_TF);
            cls.ovr_tf  = (code == MC_OVR_TF);
            cls.rst_rt  = (code == MC_RST_RT);
            cls.dbc     = (code == MC_DBC);
        end
    end
endmodule

// File: rtl/rt_resp_timer.sv
// Response window timer. After a command strobe it samples busy and
// service request at edge BUSY_EDGE, accepts a message-error rising edge
// on edges 1..ME_WIN, and raises commit during the cycle before edge
// ME_WIN+1. Assumes 1 <= BUSY_EDGE <= ME_WIN and no new strobe inside
// a running window (a new strobe restarts it).
module rt_resp_timer #(
    parameter int ME_WIN    = 3,
    parameter int BUSY_EDGE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic busy_n,
    input  logic srq_n,
    input  logic meq,
    output logic commit,
    output logic busy_s,
    output logic srq_s,
    output logic me_s
);
    localparam int CNT_W = $clog2(ME_WIN + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ME_WIN);
    localparam logic [CNT_W-1:0] CNT_BUSY = CNT_W'(BUSY_EDGE - 1);

    logic             active;
    logic [CNT_W-1:0] cnt;
    logic             meq_q;

    // Commit when the window has run its full length.
    assign commit = active && (cnt == CNT_LAST) && !start;

    // Window counter, samplers and message-error edge capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            meq_q  <= 1'b0;
            busy_s <= 1'b0;
            srq_s  <= 1'b0;
            me_s   <= 1'b0;
        end else begin
            meq_q <= meq;
            if (start) begin
                active <= 1'b1;
                cnt    <= '0;
                busy_s <= 1'b0;
                srq_s  <= 1'b0;
                me_s   <= 1'b0;
            end else if (active) begin
                if (cnt == CNT_LAST) begin
                    active <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                if (cnt == CNT_BUSY) begin
                    busy_s <= !busy_n;
                    srq_s  <= !srq_n;
                end
                if ((cnt < CNT_LAST) && meq && !meq_q) begin
                    me_s <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rt_flag_policy.sv
// Flag and fault-bit keeper. Holds the pending terminal and subsystem
// flags, the terminal-flag inhibit and the sticky fault bits, and applies
// the selected clear policy at each command receipt. Set events win over
// a clear in the same cycle. Assumes cls is valid whenever rx is high.
module rt_flag_policy
    import rt_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx,
    input  cmd_cls_t         cls,
    input  logic             opt_en_n,
    input  logic             opt_next_n,
    input  logic             opt_bit_n,
    input  logic             tx_timeout,
    input  logic             hs_fail,
    input  logic             loop_fail,
    input  logic             selftest_fail,
    input  logic             addr_par_err,
    input  logic             ss_err_n,
    input  logic             shown_set,
    output logic             tf_pend,
    output logic             ssf_pend,
    output logic             tf_inh,
    output logic             tf_set,
    output logic             ssf_set,
    output logic [BIT_N-1:0] bit_word
);
    logic             since_fault;
    logic             shown;
    logic             fault_evt;
    logic             preserve;
    logic             hold_next;
    logic             clr_pol;
    logic             clr_all;
    logic [BIT_N-1:0] bit_set;

    // Fault events and the clear decision for this cycle.
    always_comb begin
        tf_set    = tx_timeout | loop_fail | selftest_fail | addr_par_err;
        ssf_set   = hs_fail | !ss_err_n;
        fault_evt = tf_set | ssf_set;
        preserve  = !opt_bit_n && since_fault && cls.tx_bit;
        hold_next = !opt_next_n && !shown;
        clr_pol   = rx && !opt_en_n && !cls.rd_last && !preserve && !hold_next;
        clr_all   = clr_pol || (rx && cls.rst_rt);
    end

    // Per-bit set sources of the fault word.
    always_comb begin
        bit_set           = '0;
        bit_set[BIT_TXTO] = tx_timeout;
        bit_set[BIT_HS]   = hs_fail;
        bit_set[BIT_LOOP] = loop_fail;
    end

    // Pending flags: cleared by policy or reset code, set by events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tf_pend  <= 1'b0;
            ssf_pend <= 1'b0;
        end else begin
            tf_pend  <= (tf_pend  & !clr_all) | tf_set;
            ssf_pend <= (ssf_pend & !clr_all) | ssf_set;
        end
    end

    // Fault position tracker and shown marker for the ordering policies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_fault <= 1'b0;
            shown       <= 1'b0;
        end else begin
            if (fault_evt) begin
                since_fault <= 1'b1;
            end else if (rx && !cls.rd_last) begin
                since_fault <= 1'b0;
            end
            if (fault_evt) begin
                shown <= 1'b0;
            end else if (shown_set) begin
                shown <= 1'b1;
            end
        end
    end

    // Terminal-flag inhibit driven by mode codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tf_inh <= 1'b0;
        end else if (rx && (cls.rst_rt || cls.ovr_tf)) begin
            tf_inh <= 1'b0;
        end else if (rx && cls.inh_tf) begin
            tf_inh <= 1'b1;
        end
    end

    // One sticky register per fault bit.
    for (genvar g = 0; g < BIT_N; g++) begin : g_bit
        logic q;
        // Sticky fault bit with policy clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= 1'b0;
            end else begin
                q <= (q & !clr_all) | bit_set[g];
            end
        end
        assign bit_word[g] = q;
    end
endmodule

// File: rtl/rt_status_mgr.sv
// Top of the status flag manager. Classifies the incoming command, runs
// the response window, applies the flag policy, builds the fresh status
// bits, keeps the replay copy and registers the response. Assumes one
// command at a time: a new strobe only after the previous response.
module rt_status_mgr
    import rt_stat_pkg::*;
#(
    parameter int ME_WIN    = 3,
    parameter int BUSY_EDGE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [SA_W-1:0]  cmd_sa,
    input  logic             cmd_tx,
    input  logic [MC_W-1:0]  cmd_code,
    input  logic             busy_n,
    input  logic             srq_n,
    input  logic             meq,
    input  logic             ss_err_n,
    input  logic             hs_fail,
    input  logic             tx_timeout,
    input  logic             loop_fail,
    input  logic             selftest_fail,
    input  logic             addr_par_err,
    input  logic             dbc_acc_n,
    input  logic             opt_en_n,
    input  logic             opt_upd_n,
    input  logic             opt_next_n,
    input  logic             opt_bit_n,
    output logic [5:0]       resp_word,
    output logic             resp_vld,
    output logic [BIT_N-1:0] bit_word,
    output logic             dbc_req
);
    cmd_cls_t cls_now;
    logic     rd_last_q;
    logic     dbc_q;
    logic     commit;
    logic     busy_s;
    logic     srq_s;
    logic     me_s;
    logic     tf_pend;
    logic     ssf_pend;
    logic     tf_inh;
    logic     tf_set;
    logic     ssf_set;
    logic     shown_set;
    stat_t    built;
    stat_t    last_q;
    stat_t    last_d;
    stat_t    resp_q;
    logic     resp_from_last;

    rt_cmd_class u_cls (
        .sa   (cmd_sa),
        .tx   (cmd_tx),
        .code (cmd_code),
        .cls  (cls_now)
    );

    rt_resp_timer #(
        .ME_WIN    (ME_WIN),
        .BUSY_EDGE (BUSY_EDGE)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (cmd_valid),
        .busy_n (busy_n),
        .srq_n  (srq_n),
        .meq    (meq),
        .commit (commit),
        .busy_s (busy_s),
        .srq_s  (srq_s),
        .me_s   (me_s)
    );

    rt_flag_policy u_pol (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx            (cmd_valid),
        .cls           (cls_now),
        .opt_en_n      (opt_en_n),
        .opt_next_n    (opt_next_n),
        .opt_bit_n     (opt_bit_n),
        .tx_timeout    (tx_timeout),
        .hs_fail       (hs_fail),
        .loop_fail     (loop_fail),
        .selftest_fail (selftest_fail),
        .addr_par_err  (addr_par_err),
        .ss_err_n      (ss_err_n),
        .shown_set     (shown_set),
        .tf_pend       (tf_pend),
        .ssf_pend      (ssf_pend),
        .tf_inh        (tf_inh),
        .tf_set        (tf_set),
        .ssf_set       (ssf_set),
        .bit_word      (bit_word)
    );

    // Hold the command classes that the response stage needs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_last_q <= 1'b0;
            dbc_q     <= 1'b0;
        end else if (cmd_valid) begin
            rd_last_q <= cls_now.rd_last;
            dbc_q     <= cls_now.dbc;
        end
    end

    // Assemble the freshly built status bits.
    always_comb begin
        built      = '0;
        built.tf   = tf_pend & !tf_inh;
        built.ssf  = ssf_pend | !ss_err_n;
        built.busy = busy_s;
        built.srq  = srq_s;
        built.me   = me_s;
        built.dbca = dbc_q & !dbc_acc_n;
    end

    // A fresh response that carries a flag marks the flag as shown.
    assign shown_set = commit && !rd_last_q && (built.tf || built.ssf);

    // Next replay copy: fault marking under the update policy, then commit.
    always_comb begin
        last_d = last_q;
        if (!opt_en_n && !opt_upd_n) begin
            last_d.tf  = last_q.tf  | (tf_set & !tf_inh);
            last_d.ssf = last_q.ssf | ssf_set;
        end
        if (commit && !rd_last_q) begin
            last_d = built;
        end
    end

    // Replay copy register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
        end else begin
            last_q <= last_d;
        end
    end

    // Response register, valid pulse and bus-control request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q         <= '0;
            resp_vld       <= 1'b0;
            resp_from_last <= 1'b0;
            dbc_req        <= 1'b0;
        end else begin
            resp_vld       <= commit;
            resp_from_last <= commit && rd_last_q;
            dbc_req        <= commit && !rd_last_q && built.dbca;
            if (commit) begin
                resp_q <= rd_last_q ? last_q : built;
            end
        end
    end

    assign resp_word = resp_q;
endmodule

// File: rtl/rt_status_mgr_chk.sv
// Checker for the status flag manager, bound to every instance of the top.
module rt_status_mgr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       resp_vld,
    input logic [5:0] resp_word,
    input logic       resp_from_last,
    input logic [5:0] last_word,
    input logic       tf_inh,
    input logic       dbc_req,
    input logic       dbc_acc_n,
    input logic [2:0] bit_word,
    input logic       tx_timeout,
    input logic       loop_fail
);
    // R2: the valid strobe never lasts two cycles.
    a_r2_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
        resp_vld |=> !resp_vld);

    // R12: a replayed response equals the copy held before the commit.
    a_r12_replay_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_vld && resp_from_last) |-> (resp_word == $past(last_word)));

    // R6: an inhibited terminal flag never appears in a fresh response.
    a_r6_inhibit_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_vld && !resp_from_last && $past(tf_inh)) |-> !resp_word[0]);

    // R14: a takeover request needs acceptance and shows in the word.
    a_r14_req_needs_acc: assert property (@(posedge clk) disable iff (!rst_n)
        dbc_req |-> ($past(!dbc_acc_n) && resp_word[1] && resp_vld));

    // R3: the timeout bit rises only after a timeout event.
    a_r3_txto_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bit_word[0]) |-> $past(tx_timeout));

    // R3: the loop-fail bit rises only after a loop failure event.
    a_r3_loop_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bit_word[2]) |-> $past(loop_fail));
endmodule

bind rt_status_mgr rt_status_mgr_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .resp_vld       (resp_vld),
    .resp_word      (resp_word),
    .resp_from_last (resp_from_last),
    .last_word      (last_q),
    .tf_inh         (tf_inh),
    .dbc_req        (dbc_req),
    .dbc_acc_n      (dbc_acc_n),
    .bit_word       (bit_word),
    .tx_timeout     (tx_timeout),
    .loop_fail      (loop_fail)
);

// File: tb/sim_rt_status_mgr.sv
// Self-checking bench: a table of command/expectation rows, then directed
// tests for reset, sampling windows, fault sources and bus control.
module sim_rt_status_mgr;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 25;

    // Row: opts[20:17] flt[16:15] cmd[14:12] busy[11] srq[10] me[9]
    //      exp_resp[8:3] exp_bit[2:0]
    localparam logic [20:0] VEC [NV] = '{
        {4'b1111, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 6'b000000, 3'b000},
        {4'b1111, 2'd0, 3'd0, 1'b1, 1'b0, 1'b0, 6'b001000, 3'b000},
        {4'b1111, 2'd0, 3'd0, 1'b0, 1'b1, 1'b1, 6'b110000, 3'b000},
        {4'b1111, 2'd1, 3'd0, 1'b0, 1'b0, 1'b0, 6'b000001, 3'b001},
        {4'b1111, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 6'b000001, 3'b001},
        {4'b1111, 2'd0, 3'd1, 1'b0, 1'b0, 1'b0, 6'b000001, 3'b001},
        {4'b1111, 2'd0, 3'd4, 1'b0, 1'b0, 1'b0, 6'b000000, 3'b001},
        {4'b1111, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 6'b000000, 3'b001},
        {4'b1111, 2'd0, 3'd5, 1'b0, 1'b0, 1'b0, 6'b000001, 3'b001},
        {4'b1111, 2'd2, 3'd0, 1'b0, 1'b0, 1'b0, 6'b000101, 3'b011},
        {4'b1111, 2'd0, 3'd6, 1'b0, 1'b0, 1'b0, 6'b000000, 3'b000},
        {4'b1111, 2'd0, 3'd2, 1'b0, 1'b0, 1'b0, 6'b000000, 3'b000},
        {4'b0111, 2'd1, 3'd0, 1'b0, 1'b0, 1'b0, 6'b000000, 3'b000},
        {4'b0111, 2'd1, 3'd1, 1'b0, 1'b0, 1'b0, 6'b000000, 3'b001},
        {4'b0111, 2'd0, 3'd3, 1'b0, 1'b0, 1'b0, 6'b000000, 3'b000},
        {4'b0011, 2'd2, 3'd1, 1'b0, 1'b0, 1'b0, 6'b000100, 3'b010},
        {4'b0011, 2'd0, 3'd2, 1'b0, 1'b0, 1'b0, 6'b000100, 3'b010},
        {4'b0011, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 6'b000000, 3'b000},
        {4'b0011, 2'd0, 3'd1, 1'b0, 1'b0, 1'b0, 6'b000000, 3'b000},
        {4'b0101, 2'd1, 3'd0, 1'b0, 1'b0, 1'b0, 6'b000001, 3'b001},
        {4'b0101, 2'd0, 3'd1, 1'b0, 1'b0, 1'b0, 6'b000001, 3'b001},
        {4'b0101, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 6'b000000, 3'b000},
        {4'b0110, 2'd1, 3'd1, 1'b0, 1'b0, 1'b0, 6'b000000, 3'b001},
        {4'b0110, 2'd0, 3'd3, 1'b0, 1'b0, 1'b0, 6'b000001, 3'b001},
        {4'b0110, 2'd0, 3'd3, 1'b0, 1'b0, 1'b0, 6'b000000, 3'b000}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [4:0] cmd_sa = '0;
    logic       cmd_tx = 1'b0;
    logic [4:0] cmd_code = '0;
    logic       busy_n = 1'b1;
    logic       srq_n = 1'b1;
    logic       meq = 1'b0;
    logic       ss_err_n = 1'b1;
    logic       hs_fail = 1'b0;
    logic       tx_timeout = 1'b0;
    logic       loop_fail = 1'b0;
    logic       selftest_fail = 1'b0;
    logic       addr_par_err = 1'b0;
    logic       dbc_acc_n = 1'b1;
    logic       opt_en_n = 1'b1;
    logic       opt_upd_n = 1'b1;
    logic       opt_next_n = 1'b1;
    logic       opt_bit_n = 1'b1;
    logic [5:0] resp_word;
    logic       resp_vld;
    logic [2:0] bit_word;
    logic       dbc_req;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rt_status_mgr u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_sa        (cmd_sa),
        .cmd_tx        (cmd_tx),
        .cmd_code      (cmd_code),
        .busy_n        (busy_n),
        .srq_n         (srq_n),
        .meq           (meq),
        .ss_err_n      (ss_err_n),
        .hs_fail       (hs_fail),
        .tx_timeout    (tx_timeout),
        .loop_fail     (loop_fail),
        .selftest_fail (selftest_fail),
        .addr_par_err  (addr_par_err),
        .dbc_acc_n     (dbc_acc_n),
        .opt_en_n      (opt_en_n),
        .opt_upd_n     (opt_upd_n),
        .opt_next_n    (opt_next_n),
        .opt_bit_n     (opt_bit_n),
        .resp_word     (resp_word),
        .resp_vld      (resp_vld),
        .bit_word      (bit_word),
        .dbc_req       (dbc_req)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Command kinds: 0 data, 1 tx-status, 2 tx-last, 3 tx-BIT, 4 inhibit,
    // 5 override, 6 reset terminal, 7 bus control.
    task automatic set_cmd(input int k);
        cmd_sa = 5'd0;
        cmd_tx = 1'b1;
        case (k)
            0: begin cmd_sa = 5'd3; cmd_tx = 1'b0; cmd_code = 5'd4; end
            1: cmd_code = 5'b00010;
            2: begin cmd_sa = 5'd31; cmd_code = 5'b10010; end
            3: cmd_code = 5'b10011;
            4: cmd_code = 5'b00110;
            5: cmd_code = 5'b00111;
            6: cmd_code = 5'b01000;
            default: cmd_code = 5'b00000;
        endcase
    endtask

    // Strobe a command; busy_at/me_at give the first edge that sees the level.
    task automatic do_cmd(input int k, input int busy_at, input bit srq, input int me_at);
        @(negedge clk);
        set_cmd(k);
        cmd_valid = 1'b1;
        srq_n = !srq;
        busy_n = 1'b1;
        meq = 1'b0;
        @(posedge clk);
        for (int e = 1; e <= 4; e++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            busy_n = !(busy_at != 0 && e >= busy_at);
            meq = (me_at != 0 && e >= me_at);
            @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic idle();
        busy_n = 1'b1;
        srq_n = 1'b1;
        meq = 1'b0;
        @(posedge clk);
    endtask

    // Fault kinds: 1 timeout, 2 handshake, 3 loop, 4 self-test, 5 parity.
    task automatic pulse_fault(input int f);
        @(negedge clk);
        case (f)
            1: tx_timeout = 1'b1;
            2: hs_fail = 1'b1;
            3: loop_fail = 1'b1;
            4: selftest_fail = 1'b1;
            default: addr_par_err = 1'b1;
        endcase
        @(posedge clk);
        @(negedge clk);
        tx_timeout = 1'b0;
        hs_fail = 1'b0;
        loop_fail = 1'b0;
        selftest_fail = 1'b0;
        addr_par_err = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {opt_en_n, opt_upd_n, opt_next_n, opt_bit_n} = 4'b1111;
        dbc_acc_n = 1'b1;
        ss_err_n = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic string tag_of(input int i);
        if (i <= 2) return "R2";
        if (i <= 4) return "R7";
        if (i == 5) return "R12";
        if (i <= 8) return "R6";
        if (i == 9) return "R4";
        if (i == 10) return "R5";
        if (i == 11) return "R12";
        if (i <= 14) return "R8";
        if (i <= 18) return "R9";
        if (i <= 21) return "R10";
        return "R11";
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: outputs in reset and just after release
        repeat (3) @(negedge clk);
        check("R1 resp in reset", {2'b0, resp_word}, 8'h00);
        check("R1 vld/dbc in reset", {6'b0, resp_vld, dbc_req}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 bit after reset", {5'b0, bit_word}, 8'h00);

        // Table walk through all policies
        for (int i = 0; i < NV; i++) begin
            logic [20:0] v;
            v = VEC[i];
            @(negedge clk);
            {opt_en_n, opt_upd_n, opt_next_n, opt_bit_n} = v[20:17];
            if (v[16:15] != 2'd0) pulse_fault(int'(v[16:15]));
            do_cmd(int'(v[14:12]), v[11] ? 1 : 0, v[10], v[9] ? 1 : 0);
            check({tag_of(i), " resp"}, {2'b0, resp_word}, {2'b0, v[8:3]});
            check({tag_of(i), " bit"}, {5'b0, bit_word}, {5'b0, v[2:0]});
            check("R2 vld", {7'b0, resp_vld}, 8'h01);
            idle();
        end

        // R2: pulse lasts one cycle; busy seen only at edge 2
        do_reset();
        do_cmd(0, 2, 1'b0, 0);
        check("R2 busy at E2", {2'b0, resp_word}, 8'b00001000);
        @(posedge clk);
        @(negedge clk);
        check("R2 vld drops", {7'b0, resp_vld}, 8'h00);
        idle();
        do_cmd(0, 3, 1'b0, 0);
        check("R2 busy late ignored", {2'b0, resp_word}, 8'h00);
        idle();

        // R13: message error window
        do_cmd(0, 0, 1'b0, 3);
        check("R13 edge at E3", {2'b0, resp_word}, 8'b00100000);
        idle();
        do_cmd(0, 0, 1'b0, 4);
        check("R13 edge at E4 ignored", {2'b0, resp_word}, 8'h00);
        idle();

        // R3: other terminal flag sources
        for (int s = 3; s <= 5; s++) begin
            do_reset();
            pulse_fault(s);
            do_cmd(0, 0, 1'b0, 0);
            check("R3 tf source", {2'b0, resp_word}, 8'b00000001);
            check("R3 bit map", {5'b0, bit_word}, (s == 3) ? 8'b00000100 : 8'h00);
            idle();
        end

        // R4: subsystem error level survives the clear policy
        do_reset();
        {opt_en_n, opt_upd_n, opt_next_n, opt_bit_n} = 4'b0111;
        ss_err_n = 1'b0;
        do_cmd(0, 0, 1'b0, 0);
        check("R4 ssf level", {2'b0, resp_word}, 8'b00000100);
        idle();
        ss_err_n = 1'b1;
        @(negedge clk);
        do_cmd(0, 0, 1'b0, 0);
        check("R4 ssf released", {2'b0, resp_word}, 8'h00);
        idle();

        // R14: bus control acceptance
        do_reset();
        dbc_acc_n = 1'b0;
        do_cmd(7, 0, 1'b0, 0);
        check("R14 accepted", {1'b0, dbc_req, resp_word}, 8'b01000010);
        idle();
        dbc_acc_n = 1'b1;
        do_cmd(7, 0, 1'b0, 0);
        check("R14 refused", {1'b0, dbc_req, resp_word}, 8'h00);
        idle();

        // R5: reset code lifts the inhibit
        do_reset();
        do_cmd(4, 0, 1'b0, 0);
        idle();
        do_cmd(6, 0, 1'b0, 0);
        idle();
        pulse_fault(1);
        do_cmd(0, 0, 1'b0, 0);
        check("R5 inhibit lifted", {2'b0, resp_word}, 8'b00000001);
        idle();

        // R1: power-up reset lifts the inhibit
        do_cmd(4, 0, 1'b0, 0);
        idle();
        do_reset();
        pulse_fault(1);
        do_cmd(0, 0, 1'b0, 0);
        check("R1 inhibit cleared", {2'b0, resp_word}, 8'b00000001);
        idle();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule